// File: doc/BRIEF.md
# Function-to-Pin Routing Crossbar

This block connects a set of on-chip peripheral function signals to a bank of general-purpose pins. Each function can be sent to any one pin of the bank, or to none. Every function owns a 7-bit select field in a small bank of write-masked registers. Two fields share each 32-bit word. A write changes only the select bits whose matching mask bits are set in the same write. Software can therefore update one function without a read-modify-write and without disturbing its neighbour.

With the default bank of 64 pins, select value v from 1 to 64 routes the function to bank pin v-1, which is GPIO pin v+7 (GPIO 8 to GPIO 71). Value 0 and every value above the bank size leave the function unrouted. For each pin, the block drives the output value and output enable of the function routed there. It also returns that pin's input level to every function that selects it. Both paths apply only while the pin's ownership bit is 0, which means the pin belongs to the multiplexer. Logic outside this block provides the ownership bits and the peripherals.

Top module: `fn_pin_xbar`

## Requirements
- R1: After reset, every select field is 0, every register reads 0, every pinOe and pinOut bit is 0 and every funcIn bit is 0.
- R2: Function f's field lives in word f/2. An even f uses data bits 6:0 with mask bits 22:16. An odd f uses data bits 14:8 with mask bits 30:24.
- R3: A write to a select field changes only the bits whose mask bits are set in that write. A write with all mask bits clear, or no write at all, leaves the field unchanged.
- R4: A field value v in 1..NUM_PINS routes the function's funcOut and funcOe to pinOut[v-1] and pinOe[v-1] (GPIO v+7). This applies from the clock edge that stores the write, including the boundary value 64, which selects bank pin 63.
- R5: A field value of 0, or a value above NUM_PINS (65 to 127 by default), routes the function nowhere, and its funcIn reads 0.
- R6: When several functions select the same pin, the lowest-numbered one drives that pin's pinOut and pinOe.
- R7: A pin whose pinOwnGpio bit is 1 gets pinOe 0 and pinOut 0, and every function selecting that pin receives funcIn 0.
- R8: A routed function whose pin has ownership bit 0 receives that pin's pinIn level on funcIn. This holds for every function that selects the pin, whether it wins the pin or not.
- R9: A read of word w returns the even field in bits 6:0 and the odd field in bits 14:8, with every other bit 0. Reads at addresses NUM_WORDS and above return 0, and writes there change nothing.
- R10: A pin that no function selects gets pinOe 0 and pinOut 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | ADDR_W | Word index of the write |
| regWrData | input | 32 | Write word: select values and their masks |
| regRdAddr | input | ADDR_W | Word index of the read |
| regRdData | output | 32 | Read word, valid in the same cycle |
| funcOut | input | NUM_FUNC | Output value from each function |
| funcOe | input | NUM_FUNC | Output enable from each function |
| funcIn | output | NUM_FUNC | Pin level returned to each function |
| pinOwnGpio | input | NUM_PINS | Per pin: 1 = pin owned elsewhere, 0 = owned by this crossbar |
| pinIn | input | NUM_PINS | Per-pin input level |
| pinOut | output | NUM_PINS | Per-pin output value |
| pinOe | output | NUM_PINS | Per-pin output enable |

## Verification
Only the select fields are stored. A write becomes visible one clock edge after the strobe is presented. From that edge on, both the register read-back and the routing of pinOut, pinOe and funcIn reflect the new value, with no further delay. Reads, pin outputs and the returned input levels are combinational in regRdAddr, funcOut, funcOe, pinIn and pinOwnGpio, so they settle in the same cycle as their stimulus. The bench therefore drives every input just after a falling edge. It samples write results at the next falling edge, after the storing rising edge. It samples combinational results one time unit after the stimulus changes.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int SEL_W    = 7;
  localparam int WORD_W   = 32;
  localparam int LO_CTL   = 0;
  localparam int HI_CTL   = 8;
  localparam int MASK_OFS = 16;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic hit;
    sel_t loVal;
    sel_t loMask;
    sel_t hiVal;
    sel_t hiMask;
  } wr_strobe_t;
endpackage

// File: rtl/fpx_regs.sv
module fpx_regs
  import fpx_pkg::*;
#(
  parameter int NUM_FUNC  = 8,
  parameter int NUM_WORDS = 4,
  parameter int ADDR_W    = 3
) (
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regWrAddr,
  input  logic [WORD_W-1:0]         regWrData,
  input  logic [ADDR_W-1:0]         regRdAddr,
  input  logic [NUM_FUNC*SEL_W-1:0] selFlat,
  output wr_strobe_t                wrStb,
  output logic [ADDR_W-1:0]         wrIdx,
  output logic [WORD_W-1:0]         regRdData
);
  localparam int PAD_FUNC = NUM_WORDS * 2;

  logic [PAD_FUNC*SEL_W-1:0] selPad;

  always_comb begin
    selPad = '0;
    selPad[NUM_FUNC*SEL_W-1:0] = selFlat;
  end

  // write decode: split the word into the two field/mask pairs
  always_comb begin
    wrStb.hit    = regWrEn && (int'(regWrAddr) < NUM_WORDS);
    wrStb.loVal  = regWrData[LO_CTL +: SEL_W];
    wrStb.loMask = regWrData[MASK_OFS + LO_CTL +: SEL_W];
    wrStb.hiVal  = regWrData[HI_CTL +: SEL_W];
    wrStb.hiMask = regWrData[MASK_OFS + HI_CTL +: SEL_W];
    wrIdx        = regWrAddr;
  end

  // read mux: mask bits and unused bits always return 0
  always_comb begin
    regRdData = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (int'(regRdAddr) == w) begin
        regRdData[LO_CTL +: SEL_W] = selPad[(2*w)*SEL_W +: SEL_W];
        regRdData[HI_CTL +: SEL_W] = selPad[(2*w+1)*SEL_W +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/fpx_route.sv
module fpx_route
  import fpx_pkg::*;
#(
  parameter int NUM_FUNC = 8,
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wr_strobe_t                wrStb,
  input  logic [ADDR_W-1:0]         wrIdx,
  input  logic [NUM_FUNC-1:0]       funcOut,
  input  logic [NUM_FUNC-1:0]       funcOe,
  input  logic [NUM_PINS-1:0]       pinOwnGpio,
  input  logic [NUM_PINS-1:0]       pinIn,
  output logic [NUM_FUNC*SEL_W-1:0] selFlat,
  output logic [NUM_FUNC-1:0]       funcIn,
  output logic [NUM_PINS-1:0]       pinOut,
  output logic [NUM_PINS-1:0]       pinOe
);
  localparam int PIN_IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_FUNC-1:0] selOk;
  logic [PIN_IW-1:0]   selPin [NUM_FUNC];

  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
    localparam int WORD = f / 2;
    sel_t selQ;
    sel_t fldVal;
    sel_t fldMask;

    if (f % 2 == 0) begin : g_lo
      assign fldVal  = wrStb.loVal;
      assign fldMask = wrStb.loMask;
    end else begin : g_hi
      assign fldVal  = wrStb.hiVal;
      assign fldMask = wrStb.hiMask;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ <= '0;
      end else if (wrStb.hit && int'(wrIdx) == WORD) begin
        selQ <= (selQ & ~fldMask) | (fldVal & fldMask);
      end
    end

    assign selFlat[f*SEL_W +: SEL_W] = selQ;
    assign selOk[f]  = (selQ != '0) && (int'(selQ) <= NUM_PINS);
    assign selPin[f] = PIN_IW'(int'(selQ) - 1);
    assign funcIn[f] = selOk[f] && !pinOwnGpio[selPin[f]] && pinIn[selPin[f]];
  end

  // pin side: scan high to low so the lowest function number wins
  always_comb begin
    pinOut = '0;
    pinOe  = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      for (int f = NUM_FUNC - 1; f >= 0; f--) begin
        if (selOk[f] && selPin[f] == PIN_IW'(p)) begin
          pinOut[p] = funcOut[f];
          pinOe[p]  = funcOe[f];
        end
      end
      if (pinOwnGpio[p]) begin
        pinOut[p] = 1'b0;
        pinOe[p]  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fn_pin_xbar.sv
module fn_pin_xbar
  import fpx_pkg::*;
#(
  parameter  int NUM_FUNC  = 8,
  parameter  int NUM_PINS  = 64,
  localparam int NUM_WORDS = (NUM_FUNC + 1) / 2,
  localparam int ADDR_W    = $clog2(NUM_WORDS) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regWrAddr,
  input  logic [WORD_W-1:0]   regWrData,
  input  logic [ADDR_W-1:0]   regRdAddr,
  output logic [WORD_W-1:0]   regRdData,
  input  logic [NUM_FUNC-1:0] funcOut,
  input  logic [NUM_FUNC-1:0] funcOe,
  output logic [NUM_FUNC-1:0] funcIn,
  input  logic [NUM_PINS-1:0] pinOwnGpio,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  wr_strobe_t                wrStb;
  logic [ADDR_W-1:0]         wrIdx;
  logic [NUM_FUNC*SEL_W-1:0] selFlat;

  fpx_regs #(
    .NUM_FUNC (NUM_FUNC),
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .regWrEn  (regWrEn),
    .regWrAddr(regWrAddr),
    .regWrData(regWrData),
    .regRdAddr(regRdAddr),
    .selFlat  (selFlat),
    .wrStb    (wrStb),
    .wrIdx    (wrIdx),
    .regRdData(regRdData)
  );

  fpx_route #(
    .NUM_FUNC(NUM_FUNC),
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W)
  ) u_route (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .wrIdx     (wrIdx),
    .funcOut   (funcOut),
    .funcOe    (funcOe),
    .pinOwnGpio(pinOwnGpio),
    .pinIn     (pinIn),
    .selFlat   (selFlat),
    .funcIn    (funcIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe)
  );
endmodule

// File: rtl/fn_pin_xbar_chk.sv
module fn_pin_xbar_chk
  import fpx_pkg::*;
#(
  parameter int NUM_FUNC = 8,
  parameter int NUM_PINS = 64
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      regWrEn,
  input logic [NUM_FUNC*SEL_W-1:0] selFlat,
  input logic [NUM_FUNC-1:0]       funcIn,
  input logic [NUM_PINS-1:0]       pinOe,
  input logic [NUM_PINS-1:0]       pinOwnGpio,
  input logic [WORD_W-1:0]         regRdData
);
  logic [NUM_FUNC-1:0] unrouted;
  logic [NUM_PINS-1:0] mapped;

  always_comb begin
    unrouted = '0;
    mapped   = '0;
    for (int f = 0; f < NUM_FUNC; f++) begin
      if (selFlat[f*SEL_W +: SEL_W] == '0 || int'(selFlat[f*SEL_W +: SEL_W]) > NUM_PINS)
        unrouted[f] = 1'b1;
      for (int p = 0; p < NUM_PINS; p++)
        if (int'(selFlat[f*SEL_W +: SEL_W]) == p + 1) mapped[p] = 1'b1;
    end
  end

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(selFlat));

  // R5
  unrouted_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcIn & unrouted) == '0);

  // R7
  owned_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & pinOwnGpio) == '0);

  // R9
  rd_mask_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[31:15] == '0 && !regRdData[7]);

  // R10
  unmapped_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & ~mapped) == '0);
endmodule

bind fn_pin_xbar fn_pin_xbar_chk #(
  .NUM_FUNC(NUM_FUNC),
  .NUM_PINS(NUM_PINS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .selFlat   (selFlat),
  .funcIn    (funcIn),
  .pinOe     (pinOe),
  .pinOwnGpio(pinOwnGpio),
  .regRdData (regRdData)
);

// File: tb/fn_pin_xbar_bench.sv
module fn_pin_xbar_bench;
  localparam int NF = 8;
  localparam int NP = 64;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regWrAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [AW-1:0] regRdAddr = '0;
  logic [31:0]   regRdData;
  logic [NF-1:0] funcOut = '0;
  logic [NF-1:0] funcOe = '0;
  logic [NF-1:0] funcIn;
  logic [NP-1:0] pinOwnGpio = '0;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut;
  logic [NP-1:0] pinOe;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  fn_pin_xbar #(.NUM_FUNC(NF), .NUM_PINS(NP)) u_fn_pin_xbar (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .funcOut(funcOut), .funcOe(funcOe), .funcIn(funcIn),
    .pinOwnGpio(pinOwnGpio), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic logic [63:0] bit64(input int i);
    return 64'h1 << i;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrWord(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn   = 1'b1;
    regWrAddr = AW'(a);
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    #1;
  endtask

  task automatic rdChk(input int a, input logic [31:0] exp, input string tag);
    regRdAddr = AW'(a);
    #1;
    chk(tag, 64'(regRdData), 64'(exp));
  endtask

  task automatic t_reset;
    funcOut = '1; funcOe = '1; pinIn = '1; pinOwnGpio = '0;
    #1;
    for (int w = 0; w < 4; w++) rdChk(w, 32'h0, "R1 reset read");
    chk("R1 reset pinOe", pinOe, 64'h0);
    chk("R1 reset pinOut", pinOut, 64'h0);
    chk("R1 reset funcIn", 64'(funcIn), 64'h0);
  endtask

  task automatic t_layout;
    // func2 -> value 5 (pin 4), func3 -> value 10 (pin 9)
    wrWord(1, 32'h7F7F_0A05);
    rdChk(1, 32'h0000_0A05, "R2 word1 layout");
    rdChk(0, 32'h0, "R2 word0 untouched");
    funcOut = 8'b0000_0100; funcOe = '1;
    #1;
    chk("R4 pinOe routes", pinOe, bit64(4) | bit64(9));
    chk("R4 pinOut routes", pinOut, bit64(4));
    chk("R8 funcIn from pins", 64'(funcIn), 64'h0C);
    chk("R10 unmapped pin idle", {63'h0, pinOe[0]}, 64'h0);
  endtask

  task automatic t_mask;
    wrWord(1, 32'h0007_7F7F);  // low three bits of func2 only
    rdChk(1, 32'h0000_0A07, "R3 partial even mask");
    #1;
    chk("R4 moved pin", pinOe, bit64(6) | bit64(9));
    wrWord(1, 32'h0000_7F7F);  // no mask bits
    rdChk(1, 32'h0000_0A07, "R3 zero mask no change");
    wrWord(1, 32'h0F00_0300);  // low four bits of func3
    rdChk(1, 32'h0000_0307, "R3 partial odd mask");
  endtask

  task automatic t_unrouted;
    // func0 = 65 (beyond bank), func1 = 64 (last pin)
    wrWord(0, 32'h7F7F_4041);
    rdChk(0, 32'h0000_4041, "R9 read word0");
    #1;
    chk("R4 boundary 64 and others", pinOe, bit64(63) | bit64(6) | bit64(2));
    chk("R5 func0 at 65 gets 0", {63'h0, funcIn[0]}, 64'h0);
    chk("R8 func1 at pin 63", {63'h0, funcIn[1]}, 64'h1);
    wrWord(0, 32'h007F_007F);  // func0 = 127
    rdChk(0, 32'h0000_407F, "R5 func0 127 stored");
    chk("R5 func0 at 127 gets 0", {63'h0, funcIn[0]}, 64'h0);
    wrWord(0, 32'h007F_0000);  // func0 = 0
    chk("R5 func0 at 0 gets 0", {63'h0, funcIn[0]}, 64'h0);
    chk("R5 no stray pins", pinOe, bit64(63) | bit64(6) | bit64(2));
  endtask

  task automatic t_collision;
    wrWord(2, 32'h7F7F_1414);  // func4 and func5 -> value 20 (pin 19)
    funcOut = 8'b0010_0000;    // f4=0, f5=1
    funcOe  = 8'b1101_1111;    // f4=1, f5=0
    pinIn   = bit64(19);
    #1;
    chk("R6 low function wins oe", {63'h0, pinOe[19]}, 64'h1);
    chk("R6 low function wins out", {63'h0, pinOut[19]}, 64'h0);
    chk("R8 both get input", 64'(funcIn), 64'h30);
  endtask

  task automatic t_owned;
    pinOwnGpio = bit64(19);
    #1;
    chk("R7 owned pin oe", {63'h0, pinOe[19]}, 64'h0);
    chk("R7 owned pin out", {63'h0, pinOut[19]}, 64'h0);
    chk("R7 owned pin input blocked", 64'(funcIn), 64'h0);
    chk("R7 other pins keep", pinOe, bit64(63) | bit64(6) | bit64(2));
    pinOwnGpio = '0;
    #1;
    chk("R7 release restores", {63'h0, pinOe[19]}, 64'h1);
  endtask

  task automatic t_oob;
    wrWord(5, 32'hFFFF_FFFF);
    rdChk(5, 32'h0, "R9 out-of-range read");
    rdChk(0, 32'h0000_4000, "R9 word0 intact");
    rdChk(1, 32'h0000_0307, "R9 word1 intact");
    rdChk(2, 32'h0000_1414, "R9 word2 intact");
    rdChk(3, 32'h0, "R9 word3 intact");
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_layout();
    t_mask();
    t_unrouted();
    t_collision();
    t_owned();
    t_oob();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule